// File: doc/BRIEF.md
# Shared-Bus Multicycle Datapath

This block is the datapath half of a microcoded 32-bit processor. Every unit trades words over a single internal bus. An external sequencer drives the control inputs each cycle: it picks which unit places a word on the bus and which registers capture it at the next clock edge. The storage inside the block is:

- an instruction register;
- two ALU operand registers;
- a memory address register;
- a 64-entry register file that holds the 32 general registers, the program counter at entry 32, and spare entries;
- a small word memory that needs several cycles per access.

An immediate extender and an ALU with a zero flag complete the datapath. The sequencer sees the instruction's opcode and function fields, the zero flag and the memory busy line. It steps through multi-cycle instruction flows, such as fetch, decode dispatch and execute, by asserting one bus source and any set of capture strobes per cycle.

The bus is an AND-OR multiplexer with one-hot selection, not tri-state wiring. The memory model holds each enabled access busy for a fixed number of cycles before it completes.

Top module: `bus_datapath`

## Requirements
- R1: A bus source is one of four: the extender (`imm_drive`), the ALU (`alu_drive`), the register file (`rf_access`=1 with `rf_write`=0) or the memory (`mem_access`=1 with `mem_write`=0). `bus_q` equals the output of the single active source, and it reads 0 when no source is active.
- R2: Each of `ir_q`, operand A, operand B and the address register captures `bus_q` at the clock edge when its capture strobe is high, and holds its value otherwise. When several strobes are high in one cycle, each register they name captures the same word.
- R3: `alu_fn` selects the ALU result: 0 gives A, 1 gives B, 2 gives A+1, 3 gives A-1, 4 gives A+4, 5 gives A-4, 6 gives A+B and 7 gives A-B. All results are modulo 2^32.
- R4: `alu_zero` is 1 exactly when the 32-bit ALU result is zero.
- R5: `ext_kind` selects the extender output:
  - 0 zero-extends IR[15:0];
  - 1 zero-extends IR[25:0];
  - 2 sign-extends IR[15:0];
  - 3 sign-extends IR[25:0].
- R6: `rf_pick` selects the register-file address:
  - 0 gives entry 32 (program counter);
  - 1 gives entry 31 (link);
  - 2 gives IR[25:21];
  - 3 gives IR[20:16];
  - 4 gives IR[15:11];
  - 5 to 7 give entry 0.

  The 5-bit fields are zero-extended.
- R7: With `rf_access`=1 and `rf_write`=1, the addressed entry takes `bus_q` at the clock edge. With `rf_access`=0, `rf_write` has no effect.
- R8: The memory is addressed only by the address register. The word index is bits [7:2] of that register, and the read path is combinational from it.
- R9: `mem_busy` is high while `mem_access` has been held for fewer than MEM_LAT consecutive cycles (default 2). An access held continuously therefore completes in its (MEM_LAT+1)-th cycle, the first with `mem_busy` low.
- R10: A memory write takes `bus_q` only at the edge that ends its completing cycle. A write dropped while busy leaves the memory unchanged, and with `mem_access`=0, `mem_write` has no effect.
- R11: `op_field` shows IR[31:26] and `fn_field` shows IR[5:0].
- R12: Reset clears IR, both operands, the address register, every register-file entry and every memory word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imm_drive | input | 1 | Extender drives the bus |
| alu_drive | input | 1 | ALU drives the bus |
| rf_access | input | 1 | Register-file access enable |
| rf_write | input | 1 | Register-file access is a write |
| mem_access | input | 1 | Memory access enable |
| mem_write | input | 1 | Memory access is a write |
| cap_ir | input | 1 | Capture bus into IR |
| cap_a | input | 1 | Capture bus into operand A |
| cap_b | input | 1 | Capture bus into operand B |
| cap_addr | input | 1 | Capture bus into address register |
| rf_pick | input | 3 | Register address source select |
| ext_kind | input | 2 | Extender mode |
| alu_fn | input | 3 | ALU function |
| bus_q | output | 32 | Current bus value |
| op_field | output | 6 | IR opcode field |
| fn_field | output | 6 | IR function field |
| alu_zero | output | 1 | ALU result is zero |
| mem_busy | output | 1 | Memory access not yet complete |

## Verification
The assertions take two things about the sequencer for granted. First, at most one bus source is active per cycle. Second, the address register is not reloaded while a memory access is busy, so the busy countdown and the pending write always refer to one word. The stimulus keeps within both assumptions: each helper task raises exactly one source and clears every control before the next cycle. Memory accesses are loaded with their address before the access starts, and the address is left untouched until the busy line drops or the access is dropped on purpose.

// File: rtl/bus_datapath.sv
module bus_datapath #(
  parameter int DW      = 32,
  parameter int RF_AW   = 6,
  parameter int MEM_AW  = 6,
  parameter int MEM_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          imm_drive,
  input  logic          alu_drive,
  input  logic          rf_access,
  input  logic          rf_write,
  input  logic          mem_access,
  input  logic          mem_write,
  input  logic          cap_ir,
  input  logic          cap_a,
  input  logic          cap_b,
  input  logic          cap_addr,
  input  logic [2:0]    rf_pick,
  input  logic [1:0]    ext_kind,
  input  logic [2:0]    alu_fn,
  output logic [DW-1:0] bus_q,
  output logic [5:0]    op_field,
  output logic [5:0]    fn_field,
  output logic          alu_zero,
  output logic          mem_busy
);
  localparam int RF_N  = 1 << RF_AW;
  localparam int MEM_N = 1 << MEM_AW;
  localparam int CW    = $clog2(MEM_LAT + 2);
  localparam logic [RF_AW-1:0] PC_ADDR   = RF_AW'(32);
  localparam logic [RF_AW-1:0] LINK_ADDR = RF_AW'(31);
  localparam logic [CW-1:0]    LAT_W     = CW'(MEM_LAT);

  logic [DW-1:0] ir_q, opa_q, opb_q, addr_q;
  logic [DW-1:0] imm_val, alu_res, rf_rd, mem_rd;
  logic [DW-1:0] rf_q  [RF_N];
  logic [DW-1:0] mem_q [MEM_N];
  logic [RF_AW-1:0]  rf_addr;
  logic [MEM_AW-1:0] mem_idx;
  logic [CW-1:0]     wait_q;
  logic [3:0]        drv;
  logic rf_drv, mem_drv, mem_done;

  assign op_field = ir_q[31:26];
  assign fn_field = ir_q[5:0];

  always_comb begin
    case (ext_kind)
      2'd0:    imm_val = {{(DW-16){1'b0}}, ir_q[15:0]};
      2'd1:    imm_val = {{(DW-26){1'b0}}, ir_q[25:0]};
      2'd2:    imm_val = {{(DW-16){ir_q[15]}}, ir_q[15:0]};
      default: imm_val = {{(DW-26){ir_q[25]}}, ir_q[25:0]};
    endcase
  end

  always_comb begin
    case (alu_fn)
      3'd0:    alu_res = opa_q;
      3'd1:    alu_res = opb_q;
      3'd2:    alu_res = opa_q + DW'(1);
      3'd3:    alu_res = opa_q - DW'(1);
      3'd4:    alu_res = opa_q + DW'(4);
      3'd5:    alu_res = opa_q - DW'(4);
      3'd6:    alu_res = opa_q + opb_q;
      default: alu_res = opa_q - opb_q;
    endcase
  end

  assign alu_zero = (alu_res == '0);

  always_comb begin
    case (rf_pick)
      3'd0:    rf_addr = PC_ADDR;
      3'd1:    rf_addr = LINK_ADDR;
      3'd2:    rf_addr = RF_AW'(ir_q[25:21]);
      3'd3:    rf_addr = RF_AW'(ir_q[20:16]);
      3'd4:    rf_addr = RF_AW'(ir_q[15:11]);
      default: rf_addr = '0;
    endcase
  end

  assign rf_rd   = rf_q[rf_addr];
  assign mem_idx = MEM_AW'(addr_q >> 2);
  assign mem_rd  = mem_q[mem_idx];

  assign rf_drv  = rf_access & ~rf_write;
  assign mem_drv = mem_access & ~mem_write;
  assign drv     = {imm_drive, alu_drive, rf_drv, mem_drv};

  assign bus_q = ({DW{imm_drive}} & imm_val) |
                 ({DW{alu_drive}} & alu_res) |
                 ({DW{rf_drv}}    & rf_rd)   |
                 ({DW{mem_drv}}   & mem_rd);

  assign mem_busy = mem_access && (wait_q < LAT_W);
  assign mem_done = mem_access && !mem_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ir_q   <= '0;
      opa_q  <= '0;
      opb_q  <= '0;
      addr_q <= '0;
      wait_q <= '0;
    end else begin
      if (cap_ir)   ir_q   <= bus_q;
      if (cap_a)    opa_q  <= bus_q;
      if (cap_b)    opb_q  <= bus_q;
      if (cap_addr) addr_q <= bus_q;
      if (!mem_access || mem_done) wait_q <= '0;
      else                         wait_q <= wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < RF_N; i++) rf_q[i] <= '0;
    end else if (rf_access && rf_write) begin
      rf_q[rf_addr] <= bus_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_N; i++) mem_q[i] <= '0;
    end else if (mem_done && mem_write) begin
      mem_q[mem_idx] <= bus_q;
    end
  end

  // R1
  bus_one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drv) <= 1);

  // R2
  opa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_a |=> $stable(opa_q));

  // R2
  ir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ir |=> (ir_q == $past(bus_q)));

  // R3
  inc4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == 3'd4) |-> ((alu_res - opa_q) == DW'(4)));

  // R4
  zero_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_fn == 3'd7 && opa_q == opb_q) |-> alu_zero);

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_access && rf_write) |=> $stable(rf_q[PC_ADDR]));

  // R8
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_busy |-> !cap_addr);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_access && wait_q == '0 && LAT_W != '0) |-> mem_busy);

  // R10
  mem_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_busy && !cap_addr) |=> $stable(mem_q[mem_idx]));

  // R10
  mem_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_access && !cap_addr) |=> $stable(mem_q[mem_idx]));
endmodule

// File: tb/bus_datapath_tb.sv
module bus_datapath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 2;
  localparam logic [2:0] P_PC = 3'd0, P_LINK = 3'd1, P_RS = 3'd2, P_RT = 3'd3, P_RD = 3'd4, P_ZERO = 3'd5;
  localparam logic [2:0] F_CPA = 3'd0, F_CPB = 3'd1, F_INC1 = 3'd2, F_DEC1 = 3'd3,
                         F_INC4 = 3'd4, F_DEC4 = 3'd5, F_ADD = 3'd6, F_SUB = 3'd7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic imm_drive, alu_drive, rf_access, rf_write, mem_access, mem_write;
  logic cap_ir, cap_a, cap_b, cap_addr;
  logic [2:0] rf_pick, alu_fn;
  logic [1:0] ext_kind;
  logic [31:0] bus_q;
  logic [5:0] op_field, fn_field;
  logic alu_zero, mem_busy;

  int checks = 0, failures = 0;
  bit done = 0;

  bus_datapath #(.MEM_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .imm_drive(imm_drive), .alu_drive(alu_drive),
    .rf_access(rf_access), .rf_write(rf_write), .mem_access(mem_access), .mem_write(mem_write),
    .cap_ir(cap_ir), .cap_a(cap_a), .cap_b(cap_b), .cap_addr(cap_addr),
    .rf_pick(rf_pick), .ext_kind(ext_kind), .alu_fn(alu_fn), .bus_q(bus_q),
    .op_field(op_field), .fn_field(fn_field), .alu_zero(alu_zero), .mem_busy(mem_busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clr();
    {imm_drive, alu_drive, rf_access, rf_write, mem_access, mem_write} = '0;
    {cap_ir, cap_a, cap_b, cap_addr} = '0;
    rf_pick = '0; alu_fn = '0; ext_kind = '0;
  endtask

  task automatic step();
    @(posedge clk); #2; clr();
  endtask

  task automatic set_link(input logic [31:0] v);
    rf_access = 1; rf_pick = P_LINK; cap_a = 1; cap_b = 1; step();
    alu_drive = 1; alu_fn = F_SUB; rf_access = 1; rf_write = 1; rf_pick = P_LINK; step();
    for (int i = 31; i >= 0; i--) begin
      rf_access = 1; rf_pick = P_LINK; cap_a = 1; cap_b = 1; step();
      alu_drive = 1; alu_fn = F_ADD; rf_access = 1; rf_write = 1; rf_pick = P_LINK; step();
      if (v[i]) begin
        rf_access = 1; rf_pick = P_LINK; cap_a = 1; step();
        alu_drive = 1; alu_fn = F_INC1; rf_access = 1; rf_write = 1; rf_pick = P_LINK; step();
      end
    end
  endtask

  task automatic mov_link(input logic [2:0] sel);
    rf_access = 1; rf_pick = P_LINK; cap_a = 1; step();
    alu_drive = 1; alu_fn = F_CPA; rf_access = 1; rf_write = 1; rf_pick = sel; step();
  endtask

  task automatic load_ab(input logic [31:0] va, input logic [31:0] vb);
    set_link(vb); mov_link(P_PC);
    set_link(va);
    rf_access = 1; rf_pick = P_LINK; cap_a = 1; step();
    rf_access = 1; rf_pick = P_PC; cap_b = 1; step();
  endtask

  task automatic load_a(input logic [31:0] v);
    set_link(v); rf_access = 1; rf_pick = P_LINK; cap_a = 1; step();
  endtask

  task automatic load_ir(input logic [31:0] v);
    set_link(v); rf_access = 1; rf_pick = P_LINK; cap_ir = 1; step();
  endtask

  task automatic set_ma(input logic [31:0] v);
    set_link(v); rf_access = 1; rf_pick = P_LINK; cap_addr = 1; step();
  endtask

  task automatic peek_rf(input logic [2:0] sel, output logic [31:0] v);
    rf_access = 1; rf_pick = sel; #1; v = bus_q; clr();
  endtask

  task automatic peek_alu(input logic [2:0] fn, output logic [31:0] v, output logic z);
    alu_drive = 1; alu_fn = fn; #1; v = bus_q; z = alu_zero; clr();
  endtask

  task automatic peek_ext(input logic [1:0] k, output logic [31:0] v);
    imm_drive = 1; ext_kind = k; #1; v = bus_q; clr();
  endtask

  task automatic mem_read(output logic [31:0] v, output int n);
    n = 0;
    forever begin
      mem_access = 1; #1;
      if (!mem_busy) begin v = bus_q; step(); break; end
      n++; step();
    end
  endtask

  task automatic mem_wr(output int n);
    n = 0;
    forever begin
      alu_drive = 1; alu_fn = F_CPA; mem_access = 1; mem_write = 1; #1;
      if (!mem_busy) begin step(); break; end
      n++; step();
    end
  endtask

  task automatic t_reset();
    logic [31:0] v; int n;
    #1; check("R1 idle bus zero", bus_q, 0);
    check("R11 R12 opcode after reset", {26'd0, op_field}, 0);
    check("R12 busy idle", {31'd0, mem_busy}, 0);
    check("R4 R12 zero flag", {31'd0, alu_zero}, 1);
    peek_rf(P_PC, v); check("R12 pc cleared", v, 0);
    mem_read(v, n); check("R12 memory cleared", v, 0);
  endtask

  task automatic t_alu();
    logic [31:0] v; logic z;
    load_ab(32'h10, 32'h3);
    peek_alu(F_CPA, v, z);  check("R3 copy A", v, 32'h10);
    peek_alu(F_CPB, v, z);  check("R3 copy B", v, 32'h3);
    peek_alu(F_INC1, v, z); check("R3 A+1", v, 32'h11);
    peek_alu(F_DEC1, v, z); check("R3 A-1", v, 32'hF);
    peek_alu(F_INC4, v, z); check("R3 A+4", v, 32'h14);
    peek_alu(F_DEC4, v, z); check("R3 A-4", v, 32'hC);
    peek_alu(F_ADD, v, z);  check("R3 A+B", v, 32'h13);
    peek_alu(F_SUB, v, z);  check("R3 A-B", v, 32'hD); check("R4 nonzero", {31'd0, z}, 0);
    load_ab(32'hFFFF_FFFF, 32'h1);
    peek_alu(F_ADD, v, z);  check("R3 add wraps", v, 0); check("R4 zero on wrap", {31'd0, z}, 1);
    peek_alu(F_INC4, v, z); check("R3 A+4 wraps", v, 32'h3);
    load_ab(32'h5, 32'h5);
    peek_alu(F_SUB, v, z);  check("R4 equal sub", {31'd0, z}, 1);
    peek_alu(F_DEC4, v, z); check("R3 A-4 small", v, 32'h1);
    load_ab(32'h0, 32'h0);
    peek_alu(F_DEC1, v, z); check("R3 A-1 underflow", v, 32'hFFFF_FFFF);
  endtask

  task automatic t_ext();
    logic [31:0] v;
    load_ir(32'h8E4A_7123);
    check("R11 opcode", {26'd0, op_field}, 32'h23);
    check("R11 funct", {26'd0, fn_field}, 32'h23);
    peek_ext(2'd0, v); check("R5 u16 pos", v, 32'h0000_7123);
    peek_ext(2'd2, v); check("R5 s16 pos", v, 32'h0000_7123);
    peek_ext(2'd1, v); check("R5 u26 neg", v, 32'h024A_7123);
    peek_ext(2'd3, v); check("R5 s26 neg", v, 32'hFE4A_7123);
    load_ir(32'h0001_F00D);
    peek_ext(2'd0, v); check("R5 u16 neg", v, 32'h0000_F00D);
    peek_ext(2'd2, v); check("R5 s16 neg", v, 32'hFFFF_F00D);
    peek_ext(2'd3, v); check("R5 s26 pos", v, 32'h0001_F00D);
  endtask

  task automatic t_regsel();
    logic [31:0] v;
    load_ir(32'h0071_F000);
    set_link(32'h1111); mov_link(P_RS);
    set_link(32'h2222); mov_link(P_RT);
    set_link(32'h3333); mov_link(P_RD);
    set_link(32'h4444); mov_link(P_PC);
    set_link(32'h5555);
    peek_rf(P_RS, v); check("R6 rs field", v, 32'h1111);
    peek_rf(P_RT, v); check("R6 rt field", v, 32'h2222);
    peek_rf(P_RD, v); check("R6 rd field", v, 32'h3333);
    peek_rf(P_PC, v); check("R6 pc entry", v, 32'h4444);
    peek_rf(P_LINK, v); check("R6 link entry", v, 32'h5555);
    load_ir(32'h0220_0000);
    peek_rf(P_RS, v); check("R6 rs reaches entry 17", v, 32'h2222);
    set_link(32'h6666); mov_link(P_ZERO);
    load_ir(32'h0000_F800);
    peek_rf(P_RS, v); check("R6 pick 5 is entry 0", v, 32'h6666);
    peek_rf(P_RD, v); check("R6 rd 31 is link", v, 32'h0000_F800);
  endtask

  task automatic t_multi();
    logic [31:0] v; logic z; int n;
    set_link(32'hC3A5_0F18);
    rf_access = 1; rf_pick = P_LINK; cap_ir = 1; cap_a = 1; cap_b = 1; cap_addr = 1; step();
    peek_alu(F_CPA, v, z); check("R2 multi A", v, 32'hC3A5_0F18);
    peek_alu(F_CPB, v, z); check("R2 multi B", v, 32'hC3A5_0F18);
    peek_ext(2'd1, v); check("R2 multi IR", v, 32'h03A5_0F18);
    check("R2 R11 multi opcode", {26'd0, op_field}, 32'h30);
    set_link(32'h77); mov_link(P_PC);
    rf_access = 1; rf_pick = P_PC; step();
    peek_alu(F_CPA, v, z); check("R2 A holds without strobe", v, 32'h77);
    mem_read(v, n); check("R8 read at captured address", v, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] v; int n;
    set_link(32'h4444); mov_link(P_PC);
    load_a(32'h9999);
    alu_drive = 1; alu_fn = F_CPA; rf_write = 1; rf_pick = P_PC; step();
    peek_rf(P_PC, v); check("R7 write ignored without access", v, 32'h4444);
    set_ma(32'h20);
    load_a(32'hABCD);
    alu_drive = 1; alu_fn = F_CPA; mem_write = 1; step();
    mem_read(v, n); check("R10 mem write ignored without access", v, 0);
  endtask

  task automatic t_mem();
    logic [31:0] v; int n;
    set_ma(32'h10);
    load_a(32'hDEAD_BEEF);
    mem_wr(n); check("R9 write busy cycles", n, LAT);
    mem_read(v, n); check("R9 read busy cycles", n, LAT);
    check("R8 R10 readback", v, 32'hDEAD_BEEF);
    load_a(32'h1234_5678);
    alu_drive = 1; alu_fn = F_CPA; mem_access = 1; mem_write = 1; #1;
    check("R9 busy in first cycle", {31'd0, mem_busy}, 1);
    step(); step();
    mem_read(v, n); check("R10 dropped write no effect", v, 32'hDEAD_BEEF);
    set_ma(32'h14);
    mem_read(v, n); check("R8 neighbour word", v, 0);
    set_ma(32'h13);
    mem_read(v, n); check("R8 low bits ignored", v, 32'hDEAD_BEEF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clr();
    repeat (3) @(posedge clk);
    #2; rst_n = 1;
    t_reset();
    t_alu();
    t_ext();
    t_regsel();
    t_multi();
    t_ignore();
    t_mem();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule